// File: doc/BRIEF.md
# Flash Write Pulse Sequencer

This block produces a single timed programming pulse for an embedded flash array. A one-cycle start strobe, presented while the block is idle, launches a fixed series of phases. First the watchdog enable is raised on its own. Next the setup enable opens a window. The program enable pulse sits inside that window, with guard times before and after it. The setup window then closes, and after a final guard time the watchdog enable drops and a done strobe marks the return to idle.

The pulse width comes from a 2-bit select that is sampled when start is accepted. Every delay is a whole number of microseconds multiplied by the parameter `CLKS_PER_US`, so the phase lengths in clock cycles are exact. The block does not decide which width to use. It also has no part in the flash array or in the watchdog timer. It only sequences the three enable lines and reports busy and done.

Top module: `flash_pulse_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in idle from the next cycle on, with `wdt_en_o`, `setup_en_o`, `prog_en_o`, `busy_o` and `done_o` all low, even if a sequence was under way.
- R2: When `start_i` is high at a clock edge while idle, in the next cycle `wdt_en_o` and `busy_o` go high while `setup_en_o` and `prog_en_o` stay low, and this watchdog-only phase lasts exactly one cycle.
- R3: `setup_en_o` then stays high with `prog_en_o` low for exactly 50 × `CLKS_PER_US` cycles before `prog_en_o` rises, and `setup_en_o` is never high without `wdt_en_o`.
- R4: `prog_en_o` stays high for exactly W × `CLKS_PER_US` consecutive cycles, where W is 10 for select 2'b00, 30 for 2'b01, and 200 for 2'b10 and 2'b11. It is only ever high while `setup_en_o` and `wdt_en_o` are high.
- R5: After `prog_en_o` falls, `setup_en_o` stays high for exactly 5 × `CLKS_PER_US` cycles and then falls.
- R6: After `setup_en_o` falls, `wdt_en_o` stays high alone for exactly 5 × `CLKS_PER_US` cycles and then falls.
- R7: `busy_o` is high in every cycle from the watchdog-only phase to the last watchdog cycle. `done_o` is high for exactly one cycle, the first idle cycle after a sequence, and is low at all other times.
- R8: `start_i` pulses and changes of `width_sel_i` while busy have no effect: the sequence in progress keeps the width selected at acceptance, and no second sequence follows.
- R9: A start presented in the done cycle is accepted, so sequences can run back to back with only the done cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| width_sel_i | input | 2 | Pulse width select, sampled on acceptance |
| wdt_en_o | output | 1 | Watchdog enable, spans the whole sequence |
| setup_en_o | output | 1 | Setup enable window |
| prog_en_o | output | 1 | Program enable pulse |
| busy_o | output | 1 | High while a sequence is running |
| done_o | output | 1 | One-cycle end-of-sequence strobe |

## Verification
The bench aims at off-by-one errors on each phase boundary. A design that loads its counter with N instead of N−1 would stretch every phase by one cycle and fall out of step with the model. The bench presents start pulses and width changes in the middle of a sequence. A design that samples the select late would produce the wrong pulse width, and one that lets start through while busy would restart or extend the sequence. It also holds start high across a done cycle, where a design that blocks acceptance would show a gap. It resets during the pulse, where enables that hold their value would stay high after reset.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARM,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_TAIL
  } phase_e;

  // Convert a microsecond figure into a clock count.
  function automatic int unsigned us_to_clks(input int unsigned us,
                                             input int unsigned clks_per_us);
    return us * clks_per_us;
  endfunction

  // Map the 2-bit select onto one of three pulse widths; code 3 aliases long.
  function automatic int unsigned pulse_us(input logic [1:0] sel,
                                           input int unsigned short_us,
                                           input int unsigned mid_us,
                                           input int unsigned long_us);
    int unsigned r;
    unique case (sel)
      2'b00:   r = short_us;
      2'b01:   r = mid_us;
      default: r = long_us;
    endcase
    return r;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fps_delay_counter.sv
module fps_delay_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // A freshly loaded nonzero value must not report expiry next cycle.
  assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    (load_i && load_val_i != '0) |=> !expired_o);

endmodule

// File: rtl/fps_width_capture.sv
module fps_width_capture
  import fps_pkg::*;
#(
  parameter int CW          = 16,
  parameter int CLKS_PER_US = 50,
  parameter int SHORT_US    = 10,
  parameter int MID_US      = 30,
  parameter int LONG_US     = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture_i,
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] pulse_clks_o
);
  logic [1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= 2'b00;
    else if (capture_i)
      sel_q <= sel_i;
  end

  assign pulse_clks_o = CW'(us_to_clks(pulse_us(sel_q, SHORT_US, MID_US, LONG_US),
                                       CLKS_PER_US));

endmodule

// File: rtl/fps_phase_ctrl.sv
module fps_phase_ctrl
  import fps_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SETUP_CLKS  = 2500,
  parameter int GUARD_CLKS  = 250
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          expired_i,
  input  logic [CW-1:0] pulse_clks_i,
  output logic          accept_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          wdt_en_o,
  output logic          setup_en_o,
  output logic          prog_en_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] GUARD_LAST = CW'(GUARD_CLKS - 1);

  phase_e phase_q, phase_d;
  logic   done_q;
  logic   seq_end_w;

  always_comb begin
    phase_d    = phase_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d  = PH_ARM;
        load_o   = 1'b1;
        accept_o = 1'b1;
      end
      PH_ARM: if (expired_i) begin
        phase_d    = PH_SETUP;
        load_o     = 1'b1;
        load_val_o = SETUP_LAST;
      end
      PH_SETUP: if (expired_i) begin
        phase_d    = PH_PULSE;
        load_o     = 1'b1;
        load_val_o = pulse_clks_i - 1'b1;
      end
      PH_PULSE: if (expired_i) begin
        phase_d    = PH_HOLD;
        load_o     = 1'b1;
        load_val_o = GUARD_LAST;
      end
      PH_HOLD: if (expired_i) begin
        phase_d    = PH_TAIL;
        load_o     = 1'b1;
        load_val_o = GUARD_LAST;
      end
      PH_TAIL: if (expired_i) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  assign seq_end_w = (phase_q == PH_TAIL) && expired_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= seq_end_w;
    end
  end

  assign wdt_en_o   = (phase_q != PH_IDLE);
  assign setup_en_o = (phase_q == PH_SETUP) || (phase_q == PH_PULSE) || (phase_q == PH_HOLD);
  assign prog_en_o  = (phase_q == PH_PULSE);
  assign busy_o     = (phase_q != PH_IDLE);
  assign done_o     = done_q;

  assert_prog_nested_R4: assert property (@(posedge clk) disable iff (rst)
    prog_en_o |-> (setup_en_o && wdt_en_o));
  assert_setup_nested_R3: assert property (@(posedge clk) disable iff (rst)
    setup_en_o |-> wdt_en_o);
  assert_wdt_leads_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_en_o) |-> !setup_en_o);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !wdt_en_o));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !expired_i) |=> $stable(phase_q));

endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq
  import fps_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int SETUP_US    = 50,
  parameter int GUARD_US    = 5,
  parameter int SHORT_US    = 10,
  parameter int MID_US      = 30,
  parameter int LONG_US     = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [1:0] width_sel_i,
  output logic       wdt_en_o,
  output logic       setup_en_o,
  output logic       prog_en_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int SETUP_CLKS = int'(us_to_clks(SETUP_US, CLKS_PER_US));
  localparam int GUARD_CLKS = int'(us_to_clks(GUARD_US, CLKS_PER_US));
  localparam int MAX_US     = int'(max3(max3(SETUP_US, GUARD_US, SHORT_US), MID_US, LONG_US));
  localparam int CW         = $clog2(MAX_US * CLKS_PER_US + 1);

  logic          accept_w;
  logic          load_w;
  logic [CW-1:0] load_val_w;
  logic          expired_w;
  logic [CW-1:0] pulse_clks_w;

  fps_width_capture #(
    .CW(CW), .CLKS_PER_US(CLKS_PER_US),
    .SHORT_US(SHORT_US), .MID_US(MID_US), .LONG_US(LONG_US)
  ) u_width (
    .clk(clk), .rst(rst), .capture_i(accept_w), .sel_i(width_sel_i),
    .pulse_clks_o(pulse_clks_w)
  );

  fps_delay_counter #(.CW(CW)) u_delay (
    .clk(clk), .rst(rst), .load_i(load_w), .load_val_i(load_val_w),
    .expired_o(expired_w)
  );

  fps_phase_ctrl #(
    .CW(CW), .SETUP_CLKS(SETUP_CLKS), .GUARD_CLKS(GUARD_CLKS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .expired_i(expired_w),
    .pulse_clks_i(pulse_clks_w), .accept_o(accept_w), .load_o(load_w),
    .load_val_o(load_val_w), .wdt_en_o(wdt_en_o), .setup_en_o(setup_en_o),
    .prog_en_o(prog_en_o), .busy_o(busy_o), .done_o(done_o)
  );

  // Segment-length tracking for the timing assertions below.
  logic [2:0] outs_w, prev_outs_q;
  int         seg_q;
  int         exp_pulse_q;

  assign outs_w = {wdt_en_o, setup_en_o, prog_en_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_outs_q <= 3'b000;
      seg_q       <= 0;
      exp_pulse_q <= 0;
    end else begin
      prev_outs_q <= outs_w;
      seg_q       <= (outs_w != prev_outs_q) ? 1 : seg_q + 1;
      if (start_i && !busy_o)
        exp_pulse_q <= (width_sel_i[1] ? LONG_US : (width_sel_i[0] ? MID_US : SHORT_US))
                       * CLKS_PER_US;
    end
  end

  initial begin
    assert_clks_positive_R3: assert (CLKS_PER_US >= 1);
  end

  assert_arm_len_R2: assert property (@(posedge clk) disable iff (rst)
    (prev_outs_q == 3'b100 && outs_w == 3'b110) |-> (seg_q == 1));
  assert_setup_len_R3: assert property (@(posedge clk) disable iff (rst)
    (prev_outs_q == 3'b110 && outs_w == 3'b111) |-> (seg_q == SETUP_CLKS));
  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
    (prev_outs_q == 3'b111 && outs_w != 3'b111) |-> (seg_q == exp_pulse_q && outs_w == 3'b110));
  assert_hold_len_R5: assert property (@(posedge clk) disable iff (rst)
    (prev_outs_q == 3'b110 && outs_w == 3'b100) |-> (seg_q == GUARD_CLKS));
  assert_tail_len_R6: assert property (@(posedge clk) disable iff (rst)
    (prev_outs_q == 3'b100 && outs_w == 3'b000) |-> (seg_q == GUARD_CLKS && done_o));

endmodule

// File: tb/flash_pulse_seq_test.sv
module flash_pulse_seq_test;
  localparam int C = 2;
  localparam int SETUP_N = 50 * C;
  localparam int GUARD_N = 5 * C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] sel = 2'b00;
  logic wdt, setup, prog, busy, done;

  int checks = 0;
  int fails  = 0;
  bit [2:0] q[$];
  bit m_busy = 0;
  bit m_done = 0;
  bit [2:0] cur = 3'b000;

  always #10 clk = ~clk;

  flash_pulse_seq #(.CLKS_PER_US(C)) uut (
    .clk(clk), .rst(rst), .start_i(start), .width_sel_i(sel),
    .wdt_en_o(wdt), .setup_en_o(setup), .prog_en_o(prog),
    .busy_o(busy), .done_o(done)
  );

  function automatic int width_n(input bit [1:0] s);
    if (s == 2'b00) return 10 * C;
    if (s == 2'b01) return 30 * C;
    return 200 * C;
  endfunction

  task automatic chk(input string req, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic tick(input bit r, input bit s, input bit [1:0] w);
    rst = r; start = s; sel = w;
    @(posedge clk);
    if (r) begin
      q.delete(); m_busy = 0; m_done = 0; cur = 3'b000;
    end else begin
      if (!m_busy && s) begin
        q.push_back(3'b100);
        for (int i = 0; i < SETUP_N; i++) q.push_back(3'b110);
        for (int i = 0; i < width_n(w); i++) q.push_back(3'b111);
        for (int i = 0; i < GUARD_N; i++) q.push_back(3'b110);
        for (int i = 0; i < GUARD_N; i++) q.push_back(3'b100);
      end
      if (q.size() > 0) begin
        cur = q.pop_front(); m_done = 0; m_busy = 1;
      end else begin
        cur = 3'b000; m_done = m_busy; m_busy = 0;
      end
    end
    @(negedge clk);
    chk(r ? "R1 wdt" : "R2/R6 wdt", wdt, cur[2]);
    chk(r ? "R1 setup" : "R3/R5 setup", setup, cur[1]);
    chk(r ? "R1 prog" : "R4 prog", prog, cur[0]);
    chk(r ? "R1 busy" : "R7 busy", busy, m_busy);
    chk(r ? "R1 done" : "R7 done", done, m_done);
  endtask

  task automatic run_to_idle();
    while (m_busy) tick(0, 0, 2'b00);
    tick(0, 0, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) tick(1, 0, 2'b00);
    repeat (4) tick(0, 0, 2'b00);
    // R2 R3 R4 R5 R6 R7: one sequence per width code
    for (int k = 0; k < 4; k++) begin
      tick(0, 1, 2'(k));
      run_to_idle();
      repeat (2) tick(0, 0, 2'b00);
    end
    // R8: start pulses and width changes while busy are ignored
    tick(0, 1, 2'b00);
    for (int i = 0; i < 40; i++) tick(0, (i % 3) == 0, 2'(i));
    run_to_idle();
    // R9: start held high over the done cycle restarts at once
    tick(0, 1, 2'b01);
    while (m_busy) tick(0, 1, 2'b01);
    tick(0, 1, 2'b00);
    while (m_busy) tick(0, 0, 2'b11);
    repeat (2) tick(0, 0, 2'b00);
    // R1: reset in the middle of a long pulse
    tick(0, 1, 2'b10);
    repeat (SETUP_N + 30) tick(0, 0, 2'b10);
    tick(1, 0, 2'b00);
    repeat (5) tick(0, 0, 2'b00);
    tick(0, 1, 2'b00);
    run_to_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule